// File: doc/BRIEF.md
# Ternary Flash Cell Controller

This block sequences erase, program and read commands over a behavioural array of three-valued flash cells. The array is arranged as blocks, each holding a fixed number of pages. Every cell stores one trit (+1, 0 or −1) and has two halves that can be erased on their own. Erasing the first half pulls a cell to −1 and erasing the second half pulls it to +1. Programming can only bring a cell from an erased value back to 0.

A host loads a page of requested trits into a page buffer through a narrow I/O port, one trit per cycle. It then issues a command that carries an opcode, a half select, a block number and a page number. The controller keeps an erased flag per block. Before a program it erases the block automatically if that flag is clear. Every erase pulse is followed by a read-back of all pages of the block, and the pulse is repeated up to a bounded number of times.

The `slow_pulses` input is part of the behavioural cell model. It sets how many initial erase pulses leave cell 0 of page 0 of the target block unchanged, so that the verify loop can be exercised.

Top module: `tnand_ctrl`

## Requirements
- R1: An erase command with half select 0 sets every cell of the block to −1, and with half select 1 to +1. On success it reports status 0 and sets that block's bit in `blk_erased`. Trit encoding: 2'b00 is 0, 2'b01 is +1, 2'b11 is −1.
- R2: A program command applies the page buffer to the addressed page cell by cell. A request of +1 on a +1 cell or −1 on a −1 cell makes the cell 0. A request of 2'b00 or 2'b10 leaves the cell unchanged. The command reports status 0.
- R3: A program is rejected with status 1 and no cell of the page changes when any cell's request is +1 or −1 and does not equal that cell's present value. This covers a request on a cell that is already 0 and a request to move a cell toward the opposite value.
- R4: A program to a block whose erased bit is clear first erases that block with the command's half select, then checks and applies the page. `pulses` reports the erase pulses used, and it is 0 when no erase ran.
- R5: `busy` is high from the cycle after a command is accepted until the cycle after the single-cycle `done` pulse. Any command presented while busy, including one during an erase, is ignored.
- R6: After each erase pulse all pages of the block are read back. If any cell is not at the erased value, the pulse is repeated, and `pulses` counts the pulses applied.
- R7: If the block is still not fully erased after MAX_RETRY+1 pulses, the command ends with status 2, `pulses` equal to MAX_RETRY+1 and the block's erased bit clear. A program whose automatic erase fails writes nothing.
- R8: `io_we` writes `io_trit` into buffer slot `io_idx` only while not busy. `page_q` shows the buffer and changes at no other time except at the end of a read.
- R9: A read command copies the addressed page into the buffer, so `page_q` holds it once `done` is seen, and reports status 0.
- R10: After reset every cell is 0, no block is marked erased, `busy` and `done` are low, `page_q` is 0 and `pulses` is 0.
- R11: A command with opcode 0 is not accepted. Opcodes: 1 erase, 2 program, 3 read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | Opcode: 0 none, 1 erase, 2 program, 3 read |
| cmd_half | input | 1 | Half select for erase: 0 gives −1, 1 gives +1 |
| cmd_blk | input | $clog2(NBLK) | Block number |
| cmd_page | input | $clog2(NPG) | Page number within the block |
| io_we | input | 1 | Page buffer trit write |
| io_idx | input | $clog2(NCELL) | Buffer slot to write |
| io_trit | input | 2 | Trit to write |
| slow_pulses | input | $clog2(MAX_RETRY+2) | Cell model: number of leading erase pulses that miss one cell |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 program rejected, 2 erase failed |
| pulses | output | $clog2(MAX_RETRY+2) | Erase pulses used by the last command |
| page_q | output | 2*NCELL | Page buffer contents, cell c at bits 2c+1:2c |
| blk_erased | output | NBLK | Per-block erased flags |

## Verification
A wrong cell state stays hidden until that page is read. A bad erased flag shows on `blk_erased` at once, and on `pulses` at the next program to that block. A verify loop that stops early or runs too long changes `pulses` and `status` at the very next `done`. A buffer that takes writes while busy shows on `page_q` on the following cycle. A faulty reject path shows on `status` and in a read-back of the same page. The bench keeps its own model of the array and reads pages back often, so each fault appears within a few commands.

// File: rtl/tnand_pkg.sv
package tnand_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_ERASE = 2'd1,
    OP_PROG  = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_REJECT = 2'd1,
    ST_EFAIL  = 2'd2
  } stat_e;

  localparam logic [1:0] T_ZERO = 2'b00;
  localparam logic [1:0] T_POS  = 2'b01;
  localparam logic [1:0] T_NEG  = 2'b11;

  // value a cell reaches when the given half is erased
  function automatic logic [1:0] erased_trit(input logic half);
    return half ? T_POS : T_NEG;
  endfunction

  // a nonzero request must match the cell's present erased value
  function automatic logic prog_trit_ok(input logic [1:0] cur, input logic [1:0] req);
    if (req == T_POS) return cur == T_POS;
    if (req == T_NEG) return cur == T_NEG;
    return 1'b1;
  endfunction

  function automatic logic [1:0] prog_trit_next(input logic [1:0] cur, input logic [1:0] req);
    if (req == T_POS || req == T_NEG) return T_ZERO;
    return cur;
  endfunction

endpackage

// File: rtl/tnand_cell_array.sv
module tnand_cell_array #(
  parameter int NBLK  = 4,
  parameter int NPG   = 4,
  parameter int NCELL = 8,
  localparam int BW   = $clog2(NBLK),
  localparam int GW   = $clog2(NPG),
  localparam int RW   = BW + GW,
  localparam int NROW = NBLK * NPG,
  localparam int PW   = 2 * NCELL
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          er_go,
  input  logic [BW-1:0] er_blk,
  input  logic          er_half,
  input  logic          er_weak,
  input  logic          pg_go,
  input  logic [RW-1:0] pg_row,
  input  logic [PW-1:0] pg_data,
  input  logic [RW-1:0] rd_row,
  output logic [PW-1:0] rd_data
);
  import tnand_pkg::*;

  logic [PW-1:0] mem [NROW];
  logic [PW-1:0] fill;

  always_comb begin
    for (int c = 0; c < NCELL; c++) fill[2*c +: 2] = erased_trit(er_half);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NROW; r++) mem[r] <= '0;
    end else if (er_go) begin
      for (int p = 0; p < NPG; p++) begin
        if (p == 0 && er_weak)
          mem[{er_blk, GW'(p)}] <= {fill[PW-1:2], mem[{er_blk, GW'(p)}][1:0]};
        else
          mem[{er_blk, GW'(p)}] <= fill;
      end
    end else if (pg_go) begin
      mem[pg_row] <= pg_data;
    end
  end

  assign rd_data = mem[rd_row];

endmodule

// File: rtl/tnand_page_buf.sv
module tnand_page_buf #(
  parameter int NCELL = 8,
  localparam int CW   = $clog2(NCELL),
  localparam int PW   = 2 * NCELL
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_we,
  input  logic [CW-1:0] io_idx,
  input  logic [1:0]    io_trit,
  input  logic          ld_go,
  input  logic [PW-1:0] ld_data,
  output logic [PW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (ld_go)  q <= ld_data;
    else if (io_we)  q[2*io_idx +: 2] <= io_trit;
  end
endmodule

// File: rtl/tnand_seq.sv
module tnand_seq #(
  parameter int NBLK      = 4,
  parameter int NPG       = 4,
  parameter int NCELL     = 8,
  parameter int MAX_RETRY = 3,
  localparam int BW  = $clog2(NBLK),
  localparam int GW  = $clog2(NPG),
  localparam int RW  = BW + GW,
  localparam int PW  = 2 * NCELL,
  localparam int PCW = $clog2(MAX_RETRY + 2)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic [1:0]     cmd_op,
  input  logic           cmd_half,
  input  logic [BW-1:0]  cmd_blk,
  input  logic [GW-1:0]  cmd_page,
  input  logic [PCW-1:0] slow_pulses,
  input  logic [PW-1:0]  arr_rd_data,
  input  logic [PW-1:0]  buf_q,
  output logic           busy,
  output logic           done,
  output logic [1:0]     status,
  output logic [PCW-1:0] pulses,
  output logic [NBLK-1:0] blk_erased,
  output logic           acc,
  output logic [BW-1:0]  act_blk,
  output logic           er_go,
  output logic           er_half,
  output logic           er_weak,
  output logic           pg_go,
  output logic [PW-1:0]  pg_data,
  output logic [RW-1:0]  arr_rd_row,
  output logic           ld_go,
  output logic           verify_miss
);
  import tnand_pkg::*;

  typedef enum logic [2:0] {
    S_IDLE, S_EPULSE, S_EVER, S_PCHK, S_PWR, S_READ, S_DONE
  } st_e;

  st_e           state;
  op_e           op_q;
  logic          half_q;
  logic [BW-1:0] blk_q;
  logic [GW-1:0] pg_sel;
  logic [GW-1:0] vpg;
  logic          page_all_erased;
  logic          page_prog_ok;

  always_comb begin
    page_all_erased = 1'b1;
    page_prog_ok    = 1'b1;
    pg_data         = arr_rd_data;
    for (int c = 0; c < NCELL; c++) begin
      if (arr_rd_data[2*c +: 2] != erased_trit(half_q)) page_all_erased = 1'b0;
      if (!prog_trit_ok(arr_rd_data[2*c +: 2], buf_q[2*c +: 2])) page_prog_ok = 1'b0;
      pg_data[2*c +: 2] = prog_trit_next(arr_rd_data[2*c +: 2], buf_q[2*c +: 2]);
    end
  end

  assign acc         = (state == S_IDLE) && cmd_valid && (cmd_op != OP_NONE);
  assign busy        = (state != S_IDLE);
  assign done        = (state == S_DONE);
  assign act_blk     = blk_q;
  assign er_go       = (state == S_EPULSE);
  assign er_half     = half_q;
  assign er_weak     = (pulses < slow_pulses);
  assign pg_go       = (state == S_PWR);
  assign ld_go       = (state == S_READ);
  assign arr_rd_row  = (state == S_EVER) ? {blk_q, vpg} : {blk_q, pg_sel};
  assign verify_miss = (state == S_EVER) && !page_all_erased;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      op_q       <= OP_NONE;
      half_q     <= 1'b0;
      blk_q      <= '0;
      pg_sel     <= '0;
      vpg        <= '0;
      pulses     <= '0;
      status     <= ST_OK;
      blk_erased <= '0;
    end else begin
      case (state)
        S_IDLE: if (acc) begin
          op_q   <= op_e'(cmd_op);
          half_q <= cmd_half;
          blk_q  <= cmd_blk;
          pg_sel <= cmd_page;
          pulses <= '0;
          vpg    <= '0;
          case (op_e'(cmd_op))
            OP_ERASE: begin
              blk_erased[cmd_blk] <= 1'b0;
              state <= S_EPULSE;
            end
            OP_PROG: state <= blk_erased[cmd_blk] ? S_PCHK : S_EPULSE;
            default: state <= S_READ;
          endcase
        end
        S_EPULSE: begin
          pulses <= pulses + 1'b1;
          vpg    <= '0;
          state  <= S_EVER;
        end
        S_EVER: begin
          if (verify_miss) begin
            if (pulses > PCW'(MAX_RETRY)) begin
              status            <= ST_EFAIL;
              blk_erased[blk_q] <= 1'b0;
              state             <= S_DONE;
            end else begin
              state <= S_EPULSE;
            end
          end else if (vpg == GW'(NPG - 1)) begin
            blk_erased[blk_q] <= 1'b1;
            if (op_q == OP_PROG) state <= S_PCHK;
            else begin
              status <= ST_OK;
              state  <= S_DONE;
            end
          end else begin
            vpg <= vpg + 1'b1;
          end
        end
        S_PCHK: begin
          if (!page_prog_ok) begin
            status <= ST_REJECT;
            state  <= S_DONE;
          end else begin
            state <= S_PWR;
          end
        end
        S_PWR: begin
          status <= ST_OK;
          state  <= S_DONE;
        end
        S_READ: begin
          status <= ST_OK;
          state  <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tnand_ctrl.sv
module tnand_ctrl #(
  parameter int NBLK      = 4,
  parameter int NPG       = 4,
  parameter int NCELL     = 8,
  parameter int MAX_RETRY = 3,
  localparam int BW  = $clog2(NBLK),
  localparam int GW  = $clog2(NPG),
  localparam int CW  = $clog2(NCELL),
  localparam int RW  = BW + GW,
  localparam int PW  = 2 * NCELL,
  localparam int PCW = $clog2(MAX_RETRY + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic            cmd_half,
  input  logic [BW-1:0]   cmd_blk,
  input  logic [GW-1:0]   cmd_page,
  input  logic            io_we,
  input  logic [CW-1:0]   io_idx,
  input  logic [1:0]      io_trit,
  input  logic [PCW-1:0]  slow_pulses,
  output logic            busy,
  output logic            done,
  output logic [1:0]      status,
  output logic [PCW-1:0]  pulses,
  output logic [PW-1:0]   page_q,
  output logic [NBLK-1:0] blk_erased
);

  logic          acc;
  logic [BW-1:0] act_blk;
  logic          er_go;
  logic          er_half;
  logic          er_weak;
  logic          pg_go;
  logic [PW-1:0] pg_data;
  logic [RW-1:0] arr_rd_row;
  logic [PW-1:0] arr_rd_data;
  logic          ld_go;
  logic          verify_miss;
  logic          buf_we;

  assign buf_we = io_we && !busy;

  tnand_seq #(
    .NBLK(NBLK), .NPG(NPG), .NCELL(NCELL), .MAX_RETRY(MAX_RETRY)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_half(cmd_half),
    .cmd_blk(cmd_blk), .cmd_page(cmd_page), .slow_pulses(slow_pulses),
    .arr_rd_data(arr_rd_data), .buf_q(page_q),
    .busy(busy), .done(done), .status(status), .pulses(pulses),
    .blk_erased(blk_erased), .acc(acc), .act_blk(act_blk),
    .er_go(er_go), .er_half(er_half), .er_weak(er_weak),
    .pg_go(pg_go), .pg_data(pg_data), .arr_rd_row(arr_rd_row),
    .ld_go(ld_go), .verify_miss(verify_miss)
  );

  tnand_cell_array #(
    .NBLK(NBLK), .NPG(NPG), .NCELL(NCELL)
  ) u_array (
    .clk(clk), .rst_n(rst_n),
    .er_go(er_go), .er_blk(act_blk), .er_half(er_half), .er_weak(er_weak),
    .pg_go(pg_go), .pg_row(arr_rd_row), .pg_data(pg_data),
    .rd_row(arr_rd_row), .rd_data(arr_rd_data)
  );

  tnand_page_buf #(
    .NCELL(NCELL)
  ) u_buf (
    .clk(clk), .rst_n(rst_n),
    .io_we(buf_we), .io_idx(io_idx), .io_trit(io_trit),
    .ld_go(ld_go), .ld_data(arr_rd_data), .q(page_q)
  );

endmodule

// File: rtl/tnand_ctrl_chk.sv
module tnand_ctrl_chk #(
  parameter int NBLK      = 4,
  parameter int NCELL     = 8,
  parameter int MAX_RETRY = 3,
  localparam int BW  = $clog2(NBLK),
  localparam int PW  = 2 * NCELL,
  localparam int PCW = $clog2(MAX_RETRY + 2)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc,
  input logic            busy,
  input logic            done,
  input logic [1:0]      status,
  input logic [PCW-1:0]  pulses,
  input logic            io_we,
  input logic [PW-1:0]   page_q,
  input logic            pg_go,
  input logic            er_go,
  input logic            verify_miss,
  input logic [NBLK-1:0] blk_erased,
  input logic [BW-1:0]   act_blk
);

  p_accept_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> busy);

  p_locked_while_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !acc);

  p_done_releases_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_buf_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !io_we) |=> $stable(page_q));

  p_prog_on_erased_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pg_go |-> blk_erased[act_blk]);

  p_pulse_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pulses <= PCW'(MAX_RETRY + 1));

  p_miss_retries_r6: assert property (@(posedge clk) disable iff (!rst_n)
    verify_miss |=> (er_go || done));

  p_fail_at_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'd2) |-> (pulses == PCW'(MAX_RETRY + 1)));

  p_fail_clears_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'd2) |-> !blk_erased[act_blk]);

endmodule

bind tnand_ctrl tnand_ctrl_chk #(
  .NBLK(NBLK), .NCELL(NCELL), .MAX_RETRY(MAX_RETRY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc(acc), .busy(busy), .done(done),
  .status(status), .pulses(pulses), .io_we(io_we), .page_q(page_q),
  .pg_go(pg_go), .er_go(er_go), .verify_miss(verify_miss),
  .blk_erased(blk_erased), .act_blk(act_blk)
);

// File: tb/tnand_ctrl_bench.sv
module tnand_ctrl_bench;

  localparam int NBLK = 4, NPG = 4, NCELL = 8, MAXR = 3;
  localparam int BW = $clog2(NBLK), GW = $clog2(NPG), CW = $clog2(NCELL);
  localparam int PW = 2 * NCELL, PCW = $clog2(MAXR + 2);
  localparam logic [1:0] ZR = 2'b00, PO = 2'b01, NE = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_half = 0, io_we = 0;
  logic [1:0] cmd_op = 0, io_trit = 0;
  logic [BW-1:0] cmd_blk = 0;
  logic [GW-1:0] cmd_page = 0;
  logic [CW-1:0] io_idx = 0;
  logic [PCW-1:0] slow_pulses = 0;
  logic busy, done;
  logic [1:0] status;
  logic [PCW-1:0] pulses;
  logic [PW-1:0] page_q;
  logic [NBLK-1:0] blk_erased;

  int checks = 0, errors = 0, cyc = 0;
  logic [PW-1:0] ref_mem [NBLK*NPG];
  logic [NBLK-1:0] ref_er;

  always #2.5 clk = ~clk;

  tnand_ctrl #(.NBLK(NBLK), .NPG(NPG), .NCELL(NCELL), .MAX_RETRY(MAXR)) u_tnand_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_half(cmd_half), .cmd_blk(cmd_blk), .cmd_page(cmd_page),
    .io_we(io_we), .io_idx(io_idx), .io_trit(io_trit), .slow_pulses(slow_pulses),
    .busy(busy), .done(done), .status(status), .pulses(pulses),
    .page_q(page_q), .blk_erased(blk_erased));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic int row(input int b, input int p);
    return b * NPG + p;
  endfunction

  // expected erase result: outcome and pulse count, model updated
  function automatic void model_erase(input int b, input logic h, input int slow,
                                      output bit ok, output int np);
    logic [1:0] tgt = h ? PO : NE;
    logic [1:0] c0 = ref_mem[row(b, 0)][1:0];
    for (int p = 0; p < NPG; p++)
      for (int c = 0; c < NCELL; c++) ref_mem[row(b, p)][2*c +: 2] = tgt;
    if (c0 == tgt) begin ok = 1; np = 1; end
    else if (slow + 1 <= MAXR + 1) begin ok = 1; np = slow + 1; end
    else begin ok = 0; np = MAXR + 1; ref_mem[row(b, 0)][1:0] = c0; end
    ref_er[b] = ok;
  endfunction

  function automatic bit model_prog_ok(input logic [PW-1:0] cur, input logic [PW-1:0] req);
    for (int c = 0; c < NCELL; c++) begin
      if ((req[2*c +: 2] == PO || req[2*c +: 2] == NE) && req[2*c +: 2] != cur[2*c +: 2])
        return 0;
    end
    return 1;
  endfunction

  function automatic logic [PW-1:0] model_prog_apply(input logic [PW-1:0] cur, input logic [PW-1:0] req);
    logic [PW-1:0] r = cur;
    for (int c = 0; c < NCELL; c++)
      if (req[2*c +: 2] == PO || req[2*c +: 2] == NE) r[2*c +: 2] = ZR;
    return r;
  endfunction

  task automatic load_page(input logic [PW-1:0] d);
    for (int c = 0; c < NCELL; c++) begin
      @(negedge clk);
      io_we = 1; io_idx = CW'(c); io_trit = d[2*c +: 2];
    end
    @(negedge clk);
    io_we = 0;
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic h, input int b, input int p,
                         output logic [1:0] st, output int np);
    int cnt = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_half = h; cmd_blk = BW'(b); cmd_page = GW'(p);
    @(negedge clk);
    cmd_valid = 0;
    check(busy === 1'b1, "R5 busy after accept", 64'(busy), 64'd1);
    while (!done && cnt < 200) begin @(negedge clk); cnt++; end
    check(done === 1'b1, "R5 completion seen", 64'(done), 64'd1);
    st = status; np = int'(pulses);
    @(negedge clk);
    check(busy === 1'b0, "R5 idle after done", 64'(busy), 64'd0);
  endtask

  task automatic read_check(input int b, input int p, input string tag);
    logic [1:0] st; int np;
    run_cmd(2'd3, 1'b0, b, p, st, np);
    check(st == 2'd0, {tag, " read status"}, 64'(st), 64'd0);
    check(page_q === ref_mem[row(b, p)], {tag, " page contents"}, 64'(page_q), 64'(ref_mem[row(b, p)]));
  endtask

  task automatic do_erase(input int b, input logic h, input int slow, input string tag);
    logic [1:0] st; int np, enp; bit eok;
    slow_pulses = PCW'(slow);
    run_cmd(2'd1, h, b, 0, st, np);
    model_erase(b, h, slow, eok, enp);
    check(st == (eok ? 2'd0 : 2'd2), {tag, " erase status"}, 64'(st), eok ? 64'd0 : 64'd2);
    check(np == enp, {tag, " erase pulses"}, 64'(np), 64'(enp));
    check(blk_erased === ref_er, {tag, " erased flags"}, 64'(blk_erased), 64'(ref_er));
    slow_pulses = 0;
  endtask

  task automatic do_prog(input int b, input int p, input logic h, input int slow,
                         input logic [PW-1:0] req, input string tag);
    logic [1:0] st, est; int np, enp; bit eok;
    load_page(req);
    slow_pulses = PCW'(slow);
    run_cmd(2'd2, h, b, p, st, np);
    enp = 0; eok = 1;
    if (!ref_er[b]) model_erase(b, h, slow, eok, enp);
    if (!eok) est = 2'd2;
    else if (!model_prog_ok(ref_mem[row(b, p)], req)) est = 2'd1;
    else begin est = 2'd0; ref_mem[row(b, p)] = model_prog_apply(ref_mem[row(b, p)], req); end
    check(st == est, {tag, " program status"}, 64'(st), 64'(est));
    check(np == enp, {tag, " program pulses"}, 64'(np), 64'(enp));
    check(blk_erased === ref_er, {tag, " erased flags"}, 64'(blk_erased), 64'(ref_er));
    slow_pulses = 0;
  endtask

  function automatic logic [PW-1:0] all_of(input logic [1:0] t);
    logic [PW-1:0] r;
    for (int c = 0; c < NCELL; c++) r[2*c +: 2] = t;
    return r;
  endfunction

  initial begin
    logic [PW-1:0] req, held;
    logic [1:0] st; int np, cnt;
    void'($urandom(32'd1234));
    for (int r = 0; r < NBLK*NPG; r++) ref_mem[r] = '0;
    ref_er = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R10 reset state
    check(busy === 1'b0 && done === 1'b0, "R10 busy/done low", 64'({busy, done}), 64'd0);
    check(page_q === '0, "R10 buffer clear", 64'(page_q), 64'd0);
    check(blk_erased === '0, "R10 no block erased", 64'(blk_erased), 64'd0);
    check(pulses === '0, "R10 pulses zero", 64'(pulses), 64'd0);
    read_check(0, 0, "R10");

    // R11 opcode 0 is not accepted
    @(negedge clk); cmd_valid = 1; cmd_op = 2'd0;
    @(negedge clk); cmd_valid = 0;
    check(busy === 1'b0, "R11 opcode 0 ignored", 64'(busy), 64'd0);

    // R1 erase to both values
    do_erase(1, 1'b0, 0, "R1 half0");
    read_check(1, 2, "R1 half0");
    do_erase(1, 1'b1, 0, "R1 half1");
    read_check(1, 3, "R1 half1");

    // R2 program +1 cells, keep others (2'b10 also keeps)
    req = all_of(ZR); req[1:0] = PO; req[5:4] = PO; req[9:8] = 2'b10;
    do_prog(1, 2, 1'b1, 0, req, "R2");
    read_check(1, 2, "R2");

    // R3 request on already-zero cell, and opposite-polarity request
    do_prog(1, 2, 1'b1, 0, req, "R3 zero cell");
    read_check(1, 2, "R3 zero cell");
    req = all_of(ZR); req[3:2] = PO; req[7:6] = NE;
    do_prog(1, 2, 1'b1, 0, req, "R3 wrong polarity");
    read_check(1, 2, "R3 wrong polarity");

    // R4 program to unerased block auto-erases with half 0
    req = all_of(NE); req[15:14] = ZR;
    do_prog(2, 1, 1'b0, 0, req, "R4");
    read_check(2, 1, "R4");
    read_check(2, 3, "R4 other page");

    // R6 erase retries
    do_erase(3, 1'b0, 2, "R6");
    read_check(3, 0, "R6");

    // R7 erase fails at the retry bound, then program with failing auto-erase
    do_erase(0, 1'b1, 7, "R7 erase");
    read_check(0, 0, "R7 erase");
    req = all_of(PO);
    do_prog(0, 1, 1'b1, 7, req, "R7 program");
    read_check(0, 1, "R7 program");

    // R5 / R8 lock: commands and buffer writes during an erase have no effect
    read_check(1, 2, "R8 setup");
    held = page_q;
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'd1; cmd_half = 1'b0; cmd_blk = BW'(1);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'd3; cmd_blk = BW'(2); cmd_page = GW'(1);
    io_we = 1; io_idx = CW'(3); io_trit = NE;
    @(negedge clk);
    cmd_valid = 0; io_we = 0;
    check(page_q === held, "R8 buffer write ignored while busy", 64'(page_q), 64'(held));
    cnt = 0;
    while (!done && cnt < 200) begin @(negedge clk); cnt++; end
    check(status == 2'd0, "R5 locked erase status", 64'(status), 64'd0);
    begin bit eok; int enp; model_erase(1, 1'b0, 0, eok, enp); end
    @(negedge clk);
    repeat (3) begin
      check(busy === 1'b0 && done === 1'b0, "R5 no command taken while busy", 64'({busy, done}), 64'd0);
      @(negedge clk);
    end
    check(page_q === held, "R8 buffer unchanged after lock test", 64'(page_q), 64'(held));

    // random mix
    for (int i = 0; i < 150; i++) begin
      int op = 1 + int'($urandom % 3);
      int b  = int'($urandom % NBLK);
      int p  = int'($urandom % NPG);
      logic h = 1'($urandom);
      int slow = ($urandom % 4 == 0) ? int'($urandom % 6) : 0;
      if (op == 1) do_erase(b, h, slow, "R6 random erase");
      else if (op == 2) begin
        logic [PW-1:0] pred;
        pred = ref_mem[row(b, p)];
        if (!ref_er[b]) pred = all_of(h ? PO : NE);
        for (int c = 0; c < NCELL; c++) begin
          int k = int'($urandom % 10);
          if (k < 4) req[2*c +: 2] = ZR;
          else if (k < 8) req[2*c +: 2] = (pred[2*c +: 2] == ZR) ? ZR : pred[2*c +: 2];
          else req[2*c +: 2] = 2'($urandom);
        end
        do_prog(b, p, h, slow, req, "R2 random program");
      end else read_check(b, p, "R9 random read");
    end

    for (int b = 0; b < NBLK; b++)
      for (int p = 0; p < NPG; p++) read_check(b, p, "R9 final sweep");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule